// File: doc/BRIEF.md
# Edge Capture and Count-Source Unit

This unit watches a set of asynchronous capture pins on behalf of a timer. Every pin goes through a synchroniser and a shared edge detector. Each channel can be set to respond to rising edges, falling edges or both. On an accepted edge, the channel's capture register latches the timer count present on `count_i`. If the channel's interrupt enable is set, it also raises a sticky flag.

The same detected edges also produce the timer's count tick. In clock mode the tick is high on every cycle. In pin mode it is a one-cycle pulse for each qualifying edge on one chosen capture pin. The counter itself and any match logic sit outside this unit and consume `tick_o` and drive `count_i`.

A simple synchronous write port and a combinational read port reach the configuration, status and capture registers. The address map is: 0 capture control, 1 count source, 2 status, 4+n capture value of channel n.

Top module: `cap_tick_unit`

## Requirements
- R1: After reset, every register reads 0, no flag is set and `tick_o` is 1 (clock mode).
- R2: A pin level change applied before clock edge k is loaded at clock edge k+2. The capture register then holds the `count_i` value present at that edge, and before edge k+2 it still reads its old value.
- R3: Capture-control bit 3n (rising enable) makes channel n load on rising edges only.
- R4: Capture-control bit 3n+1 (falling enable) makes channel n load on falling edges only.
- R5: With both edge enables set, channel n loads on every transition.
- R6: With neither edge enable set, channel n never loads and never flags, even if its interrupt enable is set.
- R7: A load on channel n sets status bit n+4 and `cap_flag_o[n]` only when capture-control bit 3n+2 is set; the load itself happens regardless of that bit.
- R8: Writing 1 to status bit n+4 clears that flag and writing 0 leaves it unchanged. If a load and a clear land on the same edge, the flag ends up set.
- R9: With count-source bits 1:0 = 0, `tick_o` is 1 on every cycle regardless of the pins.
- R10: With count-source bits 1:0 = 1 (rising), 2 (falling) or 3 (both), `tick_o` is a one-cycle pulse per qualifying edge of the pin chosen by count-source bits 3:2. It is high in the cycle after clock edge k+1, and other pins have no effect.
- R11: Capture values at addresses 4..7 are read-only, and writes to them are ignored. Capture control keeps only its 3 bits per channel, count source keeps only its low 4 bits, and status bits 3:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | NCH | Asynchronous capture pins |
| count_i | input | CW | Present timer count |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational) |
| tick_o | output | 1 | Count tick for the timer |
| cap_flag_o | output | NCH | Sticky capture flags |

## Verification
The hardest situation to reach is a flag clear that commits on the same clock edge as a new load on that channel. The pin must be raised exactly two edges before the status write is committed. The bench gets there by raising the pin on a falling clock edge and counting two falling edges. It then drives the write-one-to-clear so that its commit edge coincides with the load edge. Pin-mode ticks are checked in the single cycle where the pulse lives, with a neighbouring pin toggled to show that it is ignored.

// File: rtl/cap_tick_pkg.sv
package cap_tick_pkg;

  localparam int CTL_BITS    = 3;
  localparam int SRC_BITS    = 4;
  localparam int FLAG_BASE   = 4;
  localparam int ADDR_CTL    = 0;
  localparam int ADDR_SRC    = 1;
  localparam int ADDR_STATUS = 2;
  localparam int ADDR_VAL0   = 4;

  typedef enum logic [1:0] {
    SRC_CLOCK = 2'd0,
    SRC_RISE  = 2'd1,
    SRC_FALL  = 2'd2,
    SRC_BOTH  = 2'd3
  } src_mode_e;

  // first member is the most significant bit: on_rise sits at bit 0
  typedef struct packed {
    logic irq_en;
    logic on_fall;
    logic on_rise;
  } chan_cfg_t;

  function automatic logic edge_accept(chan_cfg_t cfg, logic rise, logic fall);
    return (cfg.on_rise & rise) | (cfg.on_fall & fall);
  endfunction

  function automatic logic tick_pick(src_mode_e mode, logic rise, logic fall);
    logic t;
    case (mode)
      SRC_RISE: t = rise;
      SRC_FALL: t = fall;
      SRC_BOTH: t = rise | fall;
      default:  t = 1'b1;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
  parameter int NCH    = 4,
  parameter int STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] rise_o,
  output logic [NCH-1:0] fall_o
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '0;
        last_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], pin_i[ch]};
        last_q  <= chain_q[STAGES-1];
      end
    end

    assign rise_o[ch] =  chain_q[STAGES-1] & ~last_q;
    assign fall_o[ch] = ~chain_q[STAGES-1] &  last_q;
  end

endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_tick_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  chan_cfg_t     cfg_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [CW-1:0] count_i,
  input  logic          clear_i,
  output logic          hit_o,
  output logic [CW-1:0] value_o,
  output logic          flag_o
);

  logic [CW-1:0] value_q;
  logic          flag_q;

  assign hit_o = edge_accept(cfg_i, rise_i, fall_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q <= '0;
    end else if (hit_o) begin
      value_q <= count_i;
    end
  end

  // a new event beats a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (hit_o && cfg_i.irq_en) begin
      flag_q <= 1'b1;
    end else if (clear_i) begin
      flag_q <= 1'b0;
    end
  end

  assign value_o = value_q;
  assign flag_o  = flag_q;

endmodule

// File: rtl/tick_source.sv
module tick_source
  import cap_tick_pkg::*;
#(
  parameter int NCH = 4
) (
  input  src_mode_e      mode_i,
  input  logic [1:0]     sel_i,
  input  logic [NCH-1:0] rise_i,
  input  logic [NCH-1:0] fall_i,
  output logic           tick_o
);

  logic pick_rise;
  logic pick_fall;

  always_comb begin
    pick_rise = 1'b0;
    pick_fall = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (int'(sel_i) == i) begin
        pick_rise = rise_i[i];
        pick_fall = fall_i[i];
      end
    end
  end

  assign tick_o = tick_pick(mode_i, pick_rise, pick_fall);

endmodule

// File: rtl/cap_regs.sv
module cap_regs
  import cap_tick_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int DW  = 32,
  parameter int AW  = 4,
  localparam int CTLW = CTL_BITS * NCH
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  input  logic [NCH-1:0]          flags_i,
  input  logic [NCH-1:0][CW-1:0]  values_i,
  output logic [CTLW-1:0]         ctl_o,
  output src_mode_e               mode_o,
  output logic [1:0]              sel_o,
  output logic [NCH-1:0]          clr_o
);

  logic [CTLW-1:0]     ctl_q;
  logic [SRC_BITS-1:0] src_q;
  logic                wr_ctl;
  logic                wr_src;
  logic                wr_status;
  logic                unused_wdata;

  assign wr_ctl    = wr_i && (addr_i == AW'(ADDR_CTL));
  assign wr_src    = wr_i && (addr_i == AW'(ADDR_SRC));
  assign wr_status = wr_i && (addr_i == AW'(ADDR_STATUS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      src_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= wdata_i[CTLW-1:0];
      if (wr_src) src_q <= wdata_i[SRC_BITS-1:0];
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_clr
    assign clr_o[n] = wr_status && wdata_i[FLAG_BASE+n];
  end

  assign unused_wdata = ^wdata_i;
  assign ctl_o  = ctl_q;
  assign mode_o = src_mode_e'(src_q[1:0]);
  assign sel_o  = src_q[3:2];

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_CTL)) begin
      rdata_o[CTLW-1:0] = ctl_q;
    end
    if (addr_i == AW'(ADDR_SRC)) begin
      rdata_o[SRC_BITS-1:0] = src_q;
    end
    if (addr_i == AW'(ADDR_STATUS)) begin
      rdata_o[FLAG_BASE +: NCH] = flags_i;
    end
    for (int n = 0; n < NCH; n++) begin
      if (addr_i == AW'(ADDR_VAL0 + n)) begin
        rdata_o[CW-1:0] = values_i[n];
      end
    end
  end

endmodule

// File: rtl/cap_tick_unit.sv
module cap_tick_unit
  import cap_tick_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int CW          = 32,
  parameter int DW          = 32,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] cap_pin_i,
  input  logic [CW-1:0]  count_i,
  input  logic           reg_wr_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  output logic           tick_o,
  output logic [NCH-1:0] cap_flag_o
);

  localparam int CTLW = CTL_BITS * NCH;

  // named internal events, observed by the bound checker
  logic [NCH-1:0]         edge_rise;
  logic [NCH-1:0]         edge_fall;
  logic [NCH-1:0]         cap_hit;
  logic [NCH-1:0]         flag_clr;
  logic [NCH-1:0][CW-1:0] cap_value;
  logic [CTLW-1:0]        ctl_word;
  src_mode_e              src_mode;
  logic [1:0]             src_sel;

  cap_sync_edge #(
    .NCH    (NCH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cap_pin_i),
    .rise_o (edge_rise),
    .fall_o (edge_fall)
  );

  cap_regs #(
    .NCH (NCH),
    .CW  (CW),
    .DW  (DW),
    .AW  (AW)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .flags_i  (cap_flag_o),
    .values_i (cap_value),
    .ctl_o    (ctl_word),
    .mode_o   (src_mode),
    .sel_o    (src_sel),
    .clr_o    (flag_clr)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    chan_cfg_t cfg;
    assign cfg = chan_cfg_t'(ctl_word[CTL_BITS*n +: CTL_BITS]);

    cap_channel #(
      .CW (CW)
    ) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cfg_i   (cfg),
      .rise_i  (edge_rise[n]),
      .fall_i  (edge_fall[n]),
      .count_i (count_i),
      .clear_i (flag_clr[n]),
      .hit_o   (cap_hit[n]),
      .value_o (cap_value[n]),
      .flag_o  (cap_flag_o[n])
    );
  end

  tick_source #(
    .NCH (NCH)
  ) u_tick (
    .mode_i (src_mode),
    .sel_i  (src_sel),
    .rise_i (edge_rise),
    .fall_i (edge_fall),
    .tick_o (tick_o)
  );

endmodule

// File: rtl/cap_tick_checker.sv
module cap_tick_checker
  import cap_tick_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CW     = 32,
  parameter int STAGES = 2,
  localparam int CTLW  = CTL_BITS * NCH
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NCH-1:0]         cap_pin_i,
  input logic [CW-1:0]          count_i,
  input logic                   tick_o,
  input logic [NCH-1:0]         cap_flag_o,
  input logic [1:0]             src_mode,
  input logic [CTLW-1:0]        ctl_word,
  input logic [NCH-1:0]         edge_rise,
  input logic [NCH-1:0]         edge_fall,
  input logic [NCH-1:0]         cap_hit,
  input logic [NCH-1:0][CW-1:0] cap_value
);

  // R9: clock mode keeps the tick high
  a_r9_clock_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_mode == 2'd0) |-> tick_o);

  // R10: in pin mode a tick only appears alongside a detected edge
  a_r10_tick_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_mode != 2'd0) && tick_o) |-> ((edge_rise | edge_fall) != '0));

  for (genvar n = 0; n < NCH; n++) begin : g_prop
    // R2: an accepted edge stores the count seen at that edge
    a_r2_load_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_hit[n] |=> (cap_value[n] == $past(count_i)));

    // R6: no edge enable, no change of the stored value
    a_r6_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_word[CTL_BITS*n +: 2] == 2'b00) |=> $stable(cap_value[n]));

    // R7: a flag only rises after an accepted edge with interrupt enabled
    a_r7_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cap_flag_o[n]) |-> $past(cap_hit[n] && ctl_word[CTL_BITS*n+2]));

    if (STAGES == 2) begin : g_lat
      // R2: synchroniser latency of two edges
      a_r2_rise_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_rise[n] |-> $past(cap_pin_i[n], 2));
      a_r2_fall_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_fall[n] |-> !$past(cap_pin_i[n], 2));
    end
  end

endmodule

bind cap_tick_unit cap_tick_checker #(
  .NCH    (NCH),
  .CW     (CW),
  .STAGES (SYNC_STAGES)
) u_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cap_pin_i  (cap_pin_i),
  .count_i    (count_i),
  .tick_o     (tick_o),
  .cap_flag_o (cap_flag_o),
  .src_mode   (src_mode),
  .ctl_word   (ctl_word),
  .edge_rise  (edge_rise),
  .edge_fall  (edge_fall),
  .cap_hit    (cap_hit),
  .cap_value  (cap_value)
);

// File: tb/test_cap_tick_unit.sv
module test_cap_tick_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pins = '0;
  logic [31:0] cnt = '0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        mid_tick, end_tick;
  logic [31:0] mid_val, end_val, rv;

  always #5 clk = ~clk;

  cap_tick_unit i_cap_tick_unit (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cap_pin_i   (pins),
    .count_i     (cnt),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .tick_o      (tick),
    .cap_flag_o  (flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // change pin ch before edge k; sample after k+1 and after k+2
  task automatic edge_step(input int ch, input logic lvl, input logic [31:0] cval);
    @(negedge clk);
    addr = 4'(4 + ch);
    pins[ch] = lvl;
    cnt = cval;
    @(negedge clk);
    @(negedge clk);
    mid_tick = tick; mid_val = rdata;
    @(negedge clk);
    end_tick = tick; end_val = rdata;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) begin
      if (a != 3) begin
        rd_reg(4'(a), rv);
        chk($sformatf("R1 reg %0d after reset", a), rv, 32'h0);
      end
    end
    chk("R1 tick after reset", {31'h0, tick}, 32'h1);
    chk("R1 flags after reset", {28'h0, flags}, 32'h0);
  endtask

  task automatic t_clock_mode;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      pins[0] = ~pins[0];
      chk("R9 tick in clock mode", {31'h0, tick}, 32'h1);
    end
    repeat (3) @(negedge clk);
    rd_reg(4'd4, rv);
    chk("R6 no enables, no load", rv, 32'h0);
    rd_reg(4'd2, rv);
    chk("R6 no enables, no flag", rv, 32'h0);
  endtask

  task automatic t_rise_only;
    wr_reg(4'd0, 32'h001);
    edge_step(0, 1'b1, 32'h100);
    chk("R2 not loaded before edge k+2", mid_val, 32'h0);
    chk("R3 rising edge loads", end_val, 32'h100);
    edge_step(0, 1'b0, 32'h200);
    chk("R3 falling edge ignored", end_val, 32'h100);
    rd_reg(4'd2, rv);
    chk("R7 load without irq enable sets no flag", rv, 32'h0);
  endtask

  task automatic t_fall_only;
    wr_reg(4'd0, 32'h010);
    edge_step(1, 1'b1, 32'h300);
    chk("R4 rising edge ignored", end_val, 32'h0);
    edge_step(1, 1'b0, 32'h400);
    chk("R4 falling edge loads", end_val, 32'h400);
  endtask

  task automatic t_both;
    wr_reg(4'd0, 32'h0C0);
    edge_step(2, 1'b1, 32'h11);
    chk("R5 rise loads", end_val, 32'h11);
    edge_step(2, 1'b0, 32'h22);
    chk("R5 fall loads", end_val, 32'h22);
  endtask

  task automatic t_none;
    wr_reg(4'd0, 32'h800);
    edge_step(3, 1'b1, 32'h33);
    chk("R6 irq only, rise no load", end_val, 32'h0);
    edge_step(3, 1'b0, 32'h44);
    chk("R6 irq only, fall no load", end_val, 32'h0);
    chk("R6 irq only, no flag", {28'h0, flags}, 32'h0);
  endtask

  task automatic t_flags;
    wr_reg(4'd0, 32'h005);
    edge_step(0, 1'b1, 32'h500);
    chk("R7 load with irq", end_val, 32'h500);
    rd_reg(4'd2, rv);
    chk("R7 status bit 4", rv, 32'h10);
    chk("R7 flag port", {28'h0, flags}, 32'h1);
    wr_reg(4'd2, 32'h0);
    rd_reg(4'd2, rv);
    chk("R8 write 0 keeps flag", rv, 32'h10);
    wr_reg(4'd2, 32'h10);
    rd_reg(4'd2, rv);
    chk("R8 write 1 clears flag", rv, 32'h0);
    edge_step(0, 1'b0, 32'h600);
    chk("R3 fall not enabled keeps value", end_val, 32'h500);
    chk("R7 no flag on ignored edge", {28'h0, flags}, 32'h0);
  endtask

  task automatic t_collide;
    @(negedge clk);
    pins[0] = 1'b1; cnt = 32'h700;
    @(negedge clk);
    @(negedge clk);
    wr = 1'b1; addr = 4'd2; wdata = 32'h10;
    @(negedge clk);
    wr = 1'b0;
    chk("R8 set beats clear on same edge", {28'h0, flags}, 32'h1);
    rd_reg(4'd4, rv);
    chk("R2 collision load value", rv, 32'h700);
    wr_reg(4'd2, 32'h10);
    chk("R8 later clear", {28'h0, flags}, 32'h0);
  endtask

  task automatic t_counter;
    wr_reg(4'd0, 32'h0);
    wr_reg(4'd1, 32'h9);
    chk("R10 idle tick low", {31'h0, tick}, 32'h0);
    edge_step(2, 1'b1, 32'h0);
    chk("R10 rise pulse", {31'h0, mid_tick}, 32'h1);
    chk("R10 pulse is one cycle", {31'h0, end_tick}, 32'h0);
    edge_step(2, 1'b0, 32'h0);
    chk("R10 rise mode ignores fall", {31'h0, mid_tick}, 32'h0);
    edge_step(1, 1'b1, 32'h0);
    chk("R10 unselected pin ignored", {31'h0, mid_tick}, 32'h0);
    wr_reg(4'd1, 32'hA);
    edge_step(2, 1'b1, 32'h0);
    chk("R10 fall mode ignores rise", {31'h0, mid_tick}, 32'h0);
    edge_step(2, 1'b0, 32'h0);
    chk("R10 fall pulse", {31'h0, mid_tick}, 32'h1);
    chk("R10 fall pulse one cycle", {31'h0, end_tick}, 32'h0);
    wr_reg(4'd1, 32'hB);
    edge_step(2, 1'b1, 32'h0);
    chk("R10 both mode rise", {31'h0, mid_tick}, 32'h1);
    edge_step(2, 1'b0, 32'h0);
    chk("R10 both mode fall", {31'h0, mid_tick}, 32'h1);
    edge_step(1, 1'b0, 32'h0);
    chk("R10 both mode other pin", {31'h0, mid_tick}, 32'h0);
    wr_reg(4'd1, 32'h0);
    chk("R9 back to clock mode", {31'h0, tick}, 32'h1);
  endtask

  task automatic t_regmap;
    wr_reg(4'd4, 32'hDEADBEEF);
    rd_reg(4'd4, rv);
    chk("R11 capture value read-only", rv, 32'h700);
    wr_reg(4'd0, 32'hFFFFFFFF);
    rd_reg(4'd0, rv);
    chk("R11 control width", rv, 32'hFFF);
    wr_reg(4'd1, 32'hFFFFFFF0);
    rd_reg(4'd1, rv);
    chk("R11 source width", rv, 32'h0);
    wr_reg(4'd0, 32'h0);
    rd_reg(4'd2, rv);
    chk("R11 status low bits zero", rv & 32'hF, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clock_mode();
    t_rise_only();
    t_fall_only();
    t_both();
    t_none();
    t_flags();
    t_collide();
    t_counter();
    t_regmap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule